// File: doc/BRIEF.md
# Command-Mode Display Command Payload Builder

This block turns a stream of 24-bit RGB pixels into the payload bytes of long packets for a serial display link that runs in command mode. Each packet holds a programmed number of pixels, emitted as three bytes each in red, green, blue order. When automatic command insertion is switched on, one display command byte goes in front of the pixels of every packet. The first packet of a frame carries the memory-write-start code (0x2C). Every later packet of that frame carries the memory-write-continue code (0x3C). A frame-start pulse sends the choice back to the start code.

When tearing-effect synchronisation is in use, packets of a new frame are held back until the tearing-effect pulse has arrived. The block also reports the packet word count and whether that count needs the two-line buffer arrangement or fits a single line buffer. A configuration that requests no line buffer is illegal in command mode. The block flags it and transfers nothing. The high-speed or low-power choice for each packet is captured when the packet starts and travels with every byte of that packet.

Top module: `dcs_payload_inserter`

## Requirements
- R1: With insertion on, a packet of N pixels is the command byte followed by 3N pixel bytes, each pixel sent as bits 23:16, then 15:8, then 7:0. The reported word count is 3N+1 and matches the number of bytes emitted.
- R2: With insertion on, the first packet that starts after a frame-start pulse carries command byte 0x2C.
- R3: With insertion on, every packet after the first in the same frame carries command byte 0x3C.
- R4: With insertion off, a packet contains only the 3N pixel bytes, and the reported word count is 3N.
- R5: With tearing-effect sync enabled, no packet starts and no pixel is accepted after a frame-start pulse until a tearing-effect pulse has been seen. A tearing-effect pulse in the same cycle as the frame-start pulse counts.
- R6: A frame-start pulse in the cycle in which a packet would start delays that start by exactly one cycle, and the delayed packet then carries 0x2C. A frame-start pulse during a packet leaves that packet unchanged.
- R7: The two-line indication is high exactly when the word count is greater than the line size in bytes (3 × LINE_PIXELS).
- R8: With the line buffer disabled (cfg_buf_en = 0), the reject flag is high, pix_ready stays low and no byte is emitted.
- R9: out_first is high only on the first byte of a packet and out_last only on its last byte, once each per packet.
- R10: out_hs equals the cfg_hs value sampled at packet start, for every byte of that packet.
- R11: After reset, out_valid is low, and the first packet carries 0x2C even without a frame-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_cmd | input | 1 | Prepend a command byte to each packet |
| cfg_te_en | input | 1 | Gate each frame on the tearing-effect pulse |
| cfg_hs | input | 1 | High-speed (1) or low-power (0) marking for the next packet |
| cfg_buf_en | input | 1 | Line buffering enabled; 0 is the illegal no-buffer request |
| cfg_pkt_pixels | input | PIX_CNT_W | Pixels per packet |
| frame_start | input | 1 | Frame-start pulse |
| te_sync | input | 1 | Tearing-effect pulse |
| pix_valid | input | 1 | Pixel available |
| pix_data | input | 24 | RGB pixel, red in bits 23:16 |
| pix_ready | output | 1 | Pixel taken this cycle when pix_valid is high |
| out_valid | output | 1 | Payload byte valid |
| out_byte | output | 8 | Payload byte |
| out_first | output | 1 | First byte of a packet |
| out_last | output | 1 | Last byte of a packet |
| out_hs | output | 1 | High-speed marking of the current packet |
| pkt_word_count | output | PIX_CNT_W+2 | Payload length in bytes |
| buf_two | output | 1 | Word count needs two line buffers |
| cfg_reject | output | 1 | Illegal no-buffer configuration |

## Verification
Two events can land in the same cycle: a frame-start pulse and the start of a packet. The bench holds the pixel source idle, then raises pix_valid and frame_start together. It judges the result by the cycle in which the first byte appears, one cycle later than in a reference start without the pulse, and by that byte being 0x2C. A second case pulses frame_start during a packet and checks that the packet comes out intact and that the next one switches back to the start code. The tearing-effect pulse and the frame-start pulse are also driven in the same cycle, and the packet must still be released.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int PIX_W  = 24;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_WR_START = 8'h2C;
  localparam logic [BYTE_W-1:0] CMD_WR_CONT  = 8'h3C;

  typedef enum logic [0:0] {SER_IDLE, SER_PIX} ser_state_e;

  // Bytes in one packet payload.
  function automatic int unsigned payload_bytes(int unsigned px, logic with_cmd);
    return px * 3 + (with_cmd ? 1 : 0);
  endfunction

  // Two buffers are needed when a packet exceeds one line.
  function automatic logic two_lines_needed(int unsigned wc, int unsigned line_px);
    return wc > line_px * 3;
  endfunction

  function automatic logic [BYTE_W-1:0] cmd_for(logic first_in_frame);
    return first_in_frame ? CMD_WR_START : CMD_WR_CONT;
  endfunction

  // Byte k of a pixel, k = 0 is the most significant (red).
  function automatic logic [BYTE_W-1:0] pix_byte(logic [PIX_W-1:0] p, int unsigned k);
    return p[(2 - k) * BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/dcs_buf_select.sv
module dcs_buf_select
  import dcs_pkg::*;
#(
  parameter int PIX_CNT_W   = 10,
  parameter int LINE_PIXELS = 1024,
  parameter int WC_W        = PIX_CNT_W + 2
) (
  input  logic [PIX_CNT_W-1:0] cfg_pkt_pixels,
  input  logic                 cfg_auto_cmd,
  input  logic                 cfg_buf_en,
  output logic [WC_W-1:0]      pkt_word_count,
  output logic                 buf_two,
  output logic                 cfg_reject
);
  logic [31:0] wc_full;

  always_comb begin
    wc_full        = payload_bytes(32'(cfg_pkt_pixels), cfg_auto_cmd);
    pkt_word_count = wc_full[WC_W-1:0];
    buf_two        = two_lines_needed(wc_full, LINE_PIXELS);
    cfg_reject     = !cfg_buf_en;
  end
endmodule

// File: rtl/dcs_frame_tracker.sv
module dcs_frame_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_te_en,
  input  logic frame_start,
  input  logic te_sync,
  input  logic pkt_start,
  output logic start_ok,
  output logic first_pkt
);
  logic te_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_seen   <= 1'b0;
      first_pkt <= 1'b1;
    end else begin
      if (frame_start) begin
        te_seen   <= te_sync;
        first_pkt <= 1'b1;
      end else begin
        te_seen <= te_seen | te_sync;
        if (pkt_start) first_pkt <= 1'b0;
      end
    end
  end

  assign start_ok = (!cfg_te_en || te_seen) && !frame_start;
endmodule

// File: rtl/dcs_pkt_serializer.sv
module dcs_pkt_serializer
  import dcs_pkg::*;
#(
  parameter int PIX_CNT_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_auto_cmd,
  input  logic                 cfg_hs,
  input  logic [PIX_CNT_W-1:0] cfg_pkt_pixels,
  input  logic                 reject,
  input  logic                 start_ok,
  input  logic                 first_pkt,
  input  logic                 pix_valid,
  input  logic [PIX_W-1:0]     pix_data,
  output logic                 pix_ready,
  output logic                 pkt_start,
  output logic                 pkt_has_cmd,
  output logic                 out_valid,
  output logic [BYTE_W-1:0]    out_byte,
  output logic                 out_first,
  output logic                 out_last,
  output logic                 out_hs
);
  ser_state_e            st;
  logic [1:0]            idx;
  logic [PIX_CNT_W-1:0]  left;
  logic [BYTE_W-1:0]     g_q, b_q;
  logic                  hs_q;
  logic                  take;

  assign pkt_start = (st == SER_IDLE) && pix_valid && start_ok && !reject
                     && (cfg_pkt_pixels != '0);
  assign pix_ready = !reject && (((st == SER_PIX) && (idx == 2'd0))
                                 || (pkt_start && !cfg_auto_cmd));
  assign take      = pix_ready && pix_valid;
  assign out_hs    = hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SER_IDLE;
      idx         <= 2'd0;
      left        <= '0;
      g_q         <= '0;
      b_q         <= '0;
      hs_q        <= 1'b0;
      pkt_has_cmd <= 1'b0;
      out_valid   <= 1'b0;
      out_byte    <= '0;
      out_first   <= 1'b0;
      out_last    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      case (st)
        SER_IDLE: begin
          if (pkt_start) begin
            pkt_has_cmd <= cfg_auto_cmd;
            hs_q        <= cfg_hs;
            left        <= cfg_pkt_pixels;
            out_valid   <= 1'b1;
            out_first   <= 1'b1;
            st          <= SER_PIX;
            if (cfg_auto_cmd) begin
              out_byte <= cmd_for(first_pkt);
              idx      <= 2'd0;
            end else begin
              out_byte <= pix_byte(pix_data, 0);
              g_q      <= pix_byte(pix_data, 1);
              b_q      <= pix_byte(pix_data, 2);
              idx      <= 2'd1;
            end
          end
        end
        SER_PIX: begin
          case (idx)
            2'd0: begin
              if (take) begin
                out_valid <= 1'b1;
                out_byte  <= pix_byte(pix_data, 0);
                g_q       <= pix_byte(pix_data, 1);
                b_q       <= pix_byte(pix_data, 2);
                idx       <= 2'd1;
              end
            end
            2'd1: begin
              out_valid <= 1'b1;
              out_byte  <= g_q;
              idx       <= 2'd2;
            end
            default: begin
              out_valid <= 1'b1;
              out_byte  <= b_q;
              idx       <= 2'd0;
              if (left == 1) begin
                out_last <= 1'b1;
                st       <= SER_IDLE;
              end else begin
                left <= left - 1'b1;
              end
            end
          endcase
        end
        default: st <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcs_payload_inserter.sv
module dcs_payload_inserter
  import dcs_pkg::*;
#(
  parameter int PIX_CNT_W   = 10,
  parameter int LINE_PIXELS = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_auto_cmd,
  input  logic                   cfg_te_en,
  input  logic                   cfg_hs,
  input  logic                   cfg_buf_en,
  input  logic [PIX_CNT_W-1:0]   cfg_pkt_pixels,
  input  logic                   frame_start,
  input  logic                   te_sync,
  input  logic                   pix_valid,
  input  logic [PIX_W-1:0]       pix_data,
  output logic                   pix_ready,
  output logic                   out_valid,
  output logic [BYTE_W-1:0]      out_byte,
  output logic                   out_first,
  output logic                   out_last,
  output logic                   out_hs,
  output logic [PIX_CNT_W+1:0]   pkt_word_count,
  output logic                   buf_two,
  output logic                   cfg_reject
);
  localparam int WC_W = PIX_CNT_W + 2;

  logic start_ok;
  logic first_pkt;
  logic pkt_start;
  logic pkt_has_cmd;

  dcs_buf_select #(
    .PIX_CNT_W(PIX_CNT_W), .LINE_PIXELS(LINE_PIXELS), .WC_W(WC_W)
  ) u_bufsel (
    .cfg_pkt_pixels(cfg_pkt_pixels),
    .cfg_auto_cmd  (cfg_auto_cmd),
    .cfg_buf_en    (cfg_buf_en),
    .pkt_word_count(pkt_word_count),
    .buf_two       (buf_two),
    .cfg_reject    (cfg_reject)
  );

  dcs_frame_tracker u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_te_en  (cfg_te_en),
    .frame_start(frame_start),
    .te_sync    (te_sync),
    .pkt_start  (pkt_start),
    .start_ok   (start_ok),
    .first_pkt  (first_pkt)
  );

  dcs_pkt_serializer #(.PIX_CNT_W(PIX_CNT_W)) u_ser (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_auto_cmd  (cfg_auto_cmd),
    .cfg_hs        (cfg_hs),
    .cfg_pkt_pixels(cfg_pkt_pixels),
    .reject        (cfg_reject),
    .start_ok      (start_ok),
    .first_pkt     (first_pkt),
    .pix_valid     (pix_valid),
    .pix_data      (pix_data),
    .pix_ready     (pix_ready),
    .pkt_start     (pkt_start),
    .pkt_has_cmd   (pkt_has_cmd),
    .out_valid     (out_valid),
    .out_byte      (out_byte),
    .out_first     (out_first),
    .out_last      (out_last),
    .out_hs        (out_hs)
  );
endmodule

// File: rtl/dcs_payload_inserter_chk.sv
module dcs_payload_inserter_chk #(
  parameter int WC_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic            te_sync,
  input logic            cfg_te_en,
  input logic            cfg_reject,
  input logic            pix_ready,
  input logic            out_valid,
  input logic [7:0]      out_byte,
  input logic            out_first,
  input logic            out_last,
  input logic            out_hs,
  input logic            pkt_has_cmd,
  input logic [WC_W-1:0] pkt_word_count
);
  logic            in_pkt;
  logic            exp_first;
  logic            te_armed;
  logic [WC_W-1:0] byte_cnt;
  logic [WC_W-1:0] cnt_now;

  assign cnt_now = out_first ? WC_W'(1) : byte_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      exp_first <= 1'b1;
      te_armed  <= 1'b0;
      byte_cnt  <= '0;
    end else begin
      if (out_valid) byte_cnt <= cnt_now;
      if (out_last) in_pkt <= 1'b0;
      else if (out_first) in_pkt <= 1'b1;
      if (frame_start) exp_first <= 1'b1;
      else if (out_first) exp_first <= 1'b0;
      te_armed <= frame_start ? te_sync : (te_armed | te_sync);
    end
  end

  a_r1_length: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> cnt_now == pkt_word_count);
  a_r2_start_code: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first && pkt_has_cmd && exp_first) |-> out_byte == 8'h2C);
  a_r3_cont_code: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first && pkt_has_cmd && !exp_first) |-> out_byte == 8'h3C);
  a_r5_te_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first && cfg_te_en) |-> te_armed);
  a_r6_frame_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !out_first);
  a_r8_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |-> !pix_ready);
  a_r9_first_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> (out_valid && !in_pkt));
  a_r9_body_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> in_pkt);
  a_r9_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r10_hs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> $stable(out_hs));
endmodule

bind dcs_payload_inserter dcs_payload_inserter_chk #(.WC_W(WC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start   (frame_start),
  .te_sync       (te_sync),
  .cfg_te_en     (cfg_te_en),
  .cfg_reject    (cfg_reject),
  .pix_ready     (pix_ready),
  .out_valid     (out_valid),
  .out_byte      (out_byte),
  .out_first     (out_first),
  .out_last      (out_last),
  .out_hs        (out_hs),
  .pkt_has_cmd   (pkt_has_cmd),
  .pkt_word_count(pkt_word_count)
);

// File: tb/dcs_payload_inserter_tb.sv
module dcs_payload_inserter_tb_top;
  localparam int PCW = 4;
  localparam int LPX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_auto_cmd = 1'b1, cfg_te_en = 1'b0, cfg_hs = 1'b1, cfg_buf_en = 1'b1;
  logic [PCW-1:0] cfg_pkt_pixels = 4'd1;
  logic frame_start = 1'b0, te_sync = 1'b0;
  logic pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic pix_ready, out_valid, out_first, out_last, out_hs, buf_two, cfg_reject;
  logic [7:0] out_byte;
  logic [PCW+1:0] pkt_word_count;

  dcs_payload_inserter #(.PIX_CNT_W(PCW), .LINE_PIXELS(LPX)) dut_i (.*);

  always #2.5 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int pix_idx = 0, want = 0, last_cnt = 0;
  bit src_en = 0, hs_pend = 0;
  logic [7:0] q_byte[$];
  bit q_first[$], q_last[$], q_hs[$];
  int q_cyc[$];

  function automatic logic [23:0] pix_of(int i);
    return {8'(i * 7 + 17), 8'(i * 13 + 34), 8'(i * 29 + 51)};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Pixel source and output capture, both working at the falling edge.
  always @(negedge clk) begin
    if (out_valid) begin
      q_byte.push_back(out_byte); q_first.push_back(out_first);
      q_last.push_back(out_last); q_hs.push_back(out_hs); q_cyc.push_back(cyc);
    end
    if (out_valid && out_last) begin
      last_cnt++;
      if (last_cnt >= want) src_en = 0;
    end
    if (hs_pend) pix_idx++;
    pix_valid = src_en;
    pix_data  = pix_of(pix_idx);
    #1 hs_pend = pix_valid && pix_ready;
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_q();
    q_byte.delete(); q_first.delete(); q_last.delete(); q_hs.delete(); q_cyc.delete();
    last_cnt = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (last_cnt < want && t < 3000) begin tick(); t++; end
    tick(2);
  endtask

  task automatic pulse(bit fs, bit te);
    frame_start = fs; te_sync = te; tick(); frame_start = 0; te_sync = 0;
  endtask

  // Run packets and compare them against bytes rebuilt from the pixel pattern.
  task automatic run_pkts(int npkt, int npix, bit autoc, bit hs, bit first_start, string ctag);
    int base, k, per, bad;
    bit flags_ok;
    cfg_pkt_pixels = PCW'(npix); cfg_auto_cmd = autoc; cfg_hs = hs;
    clear_q(); want = npkt; base = pix_idx; src_en = 1;
    wait_done();
    per = npix * 3 + (autoc ? 1 : 0);
    check(q_byte.size() == npkt * per, autoc ? "R1" : "R4", "byte count", q_byte.size(), npkt * per);
    check(int'(pkt_word_count) == per, autoc ? "R1" : "R4", "word count", pkt_word_count, per);
    if (q_byte.size() != npkt * per) return;
    k = 0;
    for (int p = 0; p < npkt; p++) begin
      if (autoc) begin
        logic [7:0] c = (p == 0 && first_start) ? 8'h2C : 8'h3C;
        check(q_byte[k] == c, p == 0 ? ctag : "R3", "command byte", q_byte[k], c);
        k++;
      end
      bad = 0;
      for (int i = 0; i < npix; i++) begin
        logic [23:0] px = pix_of(base + p * npix + i);
        for (int b = 0; b < 3; b++) begin
          if (q_byte[k] != px[(2 - b) * 8 +: 8]) bad++;
          k++;
        end
      end
      check(bad == 0, autoc ? "R1" : "R4", "pixel byte mismatches", bad, 0);
    end
    flags_ok = 1;
    for (int j = 0; j < q_byte.size(); j++) begin
      if (q_first[j] != (j % per == 0)) flags_ok = 0;
      if (q_last[j] != (j % per == per - 1)) flags_ok = 0;
    end
    check(flags_ok, "R9", "first/last flags", flags_ok, 1);
    flags_ok = 1;
    for (int j = 0; j < q_hs.size(); j++) if (q_hs[j] != hs) flags_ok = 0;
    check(flags_ok, "R10", "hs marking", flags_ok, 1);
  endtask

  task automatic t_reset();
    check(out_valid == 0, "R11", "out_valid in reset", out_valid, 0);
    check(pix_ready == 0, "R11", "pix_ready idle", pix_ready, 0);
    check(cfg_reject == 0, "R8", "reject with buffer on", cfg_reject, 0);
  endtask

  task automatic t_frames();
    run_pkts(1, 1, 1, 1, 1, "R11");
    pulse(1, 0);
    run_pkts(3, 2, 1, 1, 1, "R2");
    run_pkts(2, 3, 0, 0, 0, "R4");
    pulse(1, 0);
    run_pkts(2, 1, 1, 0, 1, "R2");
  endtask

  task automatic t_bufsel();
    cfg_auto_cmd = 1; cfg_pkt_pixels = 4'd4; #1;
    check(buf_two == 1, "R7", "13 bytes over 12", buf_two, 1);
    cfg_auto_cmd = 0; #1;
    check(buf_two == 0, "R7", "12 bytes equal line", buf_two, 0);
    cfg_auto_cmd = 1; cfg_pkt_pixels = 4'd3; #1;
    check(buf_two == 0, "R7", "10 bytes under line", buf_two, 0);
    cfg_pkt_pixels = 4'd15; #1;
    check(buf_two == 1 && pkt_word_count == 46, "R7", "46 bytes", pkt_word_count, 46);
    tick();
  endtask

  task automatic t_te();
    int idx0;
    cfg_te_en = 1; cfg_auto_cmd = 1; cfg_pkt_pixels = 4'd2; cfg_hs = 1;
    pulse(1, 0);
    clear_q(); want = 1; idx0 = pix_idx; src_en = 1;
    tick(10);
    check(q_byte.size() == 0, "R5", "bytes before te", q_byte.size(), 0);
    check(pix_idx == idx0, "R5", "pixels taken before te", pix_idx - idx0, 0);
    pulse(0, 1);
    wait_done();
    check(q_byte.size() == 7 && q_byte[0] == 8'h2C, "R5", "packet after te", q_byte.size(), 7);
    pulse(1, 1);
    run_pkts(1, 1, 1, 1, 1, "R5");
    cfg_te_en = 0;
  endtask

  task automatic t_collide();
    int c0;
    cfg_auto_cmd = 1; cfg_pkt_pixels = 4'd1;
    clear_q(); want = 1; c0 = cyc; src_en = 1;
    wait_done();
    check(q_cyc.size() > 0 && q_cyc[0] == c0 + 1, "R6", "reference start cycle",
          q_cyc.size() > 0 ? q_cyc[0] - c0 : -1, 1);
    check(q_byte.size() > 0 && q_byte[0] == 8'h3C, "R3", "reference code", q_byte[0], 8'h3C);
    clear_q(); want = 1; c0 = cyc; src_en = 1; frame_start = 1;
    tick(); frame_start = 0;
    wait_done();
    check(q_cyc.size() > 0 && q_cyc[0] == c0 + 2, "R6", "collided start cycle",
          q_cyc.size() > 0 ? q_cyc[0] - c0 : -1, 2);
    check(q_byte.size() > 0 && q_byte[0] == 8'h2C, "R6", "collided code", q_byte[0], 8'h2C);
    cfg_pkt_pixels = 4'd3;
    clear_q(); want = 2; src_en = 1;
    while (q_byte.size() < 3) tick();
    pulse(1, 0);
    wait_done();
    check(q_byte.size() == 20, "R6", "bytes with mid-packet frame", q_byte.size(), 20);
    check(q_byte.size() == 20 && q_byte[0] == 8'h3C && q_last[9] && q_byte[10] == 8'h2C,
          "R6", "codes around mid-packet frame", q_byte[10], 8'h2C);
  endtask

  task automatic t_reject();
    int idx0;
    cfg_buf_en = 0; cfg_pkt_pixels = 4'd1;
    clear_q(); want = 1; idx0 = pix_idx; src_en = 1;
    tick(8);
    check(cfg_reject == 1, "R8", "reject flag", cfg_reject, 1);
    check(q_byte.size() == 0, "R8", "bytes while rejected", q_byte.size(), 0);
    check(pix_idx == idx0 && pix_ready == 0, "R8", "pixels taken", pix_idx - idx0, 0);
    src_en = 0; tick(2); cfg_buf_en = 1; tick();
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1;
    tick(2);
    t_frames();
    t_bufsel();
    t_te();
    t_collide();
    t_reject();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #500us;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule